// File: doc/BRIEF.md
# Privileged Interrupt Priority Selector

This block decides which interrupt, if any, a hart should take right now. It takes the raw pending vector, the per-source enable vector, a per-source delegation mask, the hart's current privilege level and the two global enable bits (machine and supervisor). It returns a valid flag and the cause number of the winning interrupt.

Only a source that is both pending and enabled is a candidate. A candidate that is not delegated is gated by the machine-level global enable. A delegated candidate is gated by the supervisor-level global enable. Code running at a lower privilege always accepts interrupts meant for a higher level, whatever that level's enable bit says. Among the candidates that pass gating, the lowest-numbered source wins.

By default the result is purely combinational. A parameter adds one output register for timing.

Top module: `irq_prio_select`

## Requirements
- R1: A source can be selected only when its bit is 1 in both `pend_i` and `en_i`. If either bit is 0, that source is never reported.
- R2: The machine-level gate is open when `priv_i` is 0 (user) or 1 (supervisor). When `priv_i` is 3 (machine), the gate is open only if `m_gie_i` is 1.
- R3: The supervisor-level gate is open when `priv_i` is 0. When `priv_i` is 1, it is open only if `s_gie_i` is 1. When `priv_i` is 3, it is closed.
- R4: A candidate with its `deleg_i` bit at 0 passes only through the machine-level gate. A candidate with its `deleg_i` bit at 1 passes only through the supervisor-level gate.
- R5: When several candidates pass gating, `cause_o` is the lowest bit index among them, that is, the count of trailing zeros of the surviving vector.
- R6: When no candidate passes gating, `take_o` is 0 and `cause_o` is 0.
- R7: With `OUT_REG`=0 (the default), the outputs follow the inputs in the same cycle, with no clock edge between. With `OUT_REG`=1, the outputs are registered: they appear one clock edge after the inputs, and the register holds 0 while `rst_n` is low.
- R8: Privilege encoding 2 is never presented to the block, and its behaviour for that value is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the optional output register and the checker |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16 | Pending interrupt bits, one per source |
| en_i | input | 16 | Per-source enable bits |
| deleg_i | input | 16 | Per-source delegation to the supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | 4 | Index of the selected source |

## Verification
The hardest case to reach from the ports is a lower-numbered delegated candidate blocked by a closed supervisor gate, while a higher-numbered non-delegated candidate passes the machine gate. The selector must then skip the lowest pending bit.

Uniform random vectors rarely hit this with a visible effect. The directed cases therefore set it up explicitly in machine mode and in supervisor mode with the supervisor enable cleared. The random phase biases the delegation mask toward a half-and-half mix, so both gates are active in the same vector.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_MACH  = 2'd3
  } priv_e;

  // machine-level gate: open below machine mode, or in machine mode with its enable
  function automatic logic mach_gate_open(input logic [1:0] priv, input logic gie);
    return (priv != PRIV_MACH) || gie;
  endfunction

  // supervisor-level gate: open in user mode, or in supervisor mode with its enable
  function automatic logic super_gate_open(input logic [1:0] priv, input logic gie);
    return (priv == PRIV_USER) || ((priv == PRIV_SUPER) && gie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic [VEC_W-1:0] pend_i,
  input  logic [VEC_W-1:0] en_i,
  input  logic [VEC_W-1:0] deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  output logic [VEC_W-1:0] cand_o,
  output logic             m_live_o,
  output logic             s_live_o,
  output logic [VEC_W-1:0] surv_o
);
  always_comb begin
    cand_o   = pend_i & en_i;
    m_live_o = mach_gate_open(priv_i, m_gie_i);
    s_live_o = super_gate_open(priv_i, s_gie_i);
  end

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    assign surv_o[i] = cand_o[i] & (deleg_i[i] ? s_live_o : m_live_o);
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int VEC_W   = 16,
  parameter int CAUSE_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0]   vec_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = CAUSE_W'(i);
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int CAUSE_W = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        take_o  <= 1'b0;
        cause_o <= '0;
      end else begin
        take_o  <= take_i;
        cause_o <= cause_i;
      end
    end
  end else begin : g_comb
    assign take_o  = take_i;
    assign cause_o = cause_i;
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int VEC_W   = 16,
  parameter bit OUT_REG = 1'b0,
  localparam int CAUSE_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   pend_i,
  input  logic [VEC_W-1:0]   en_i,
  input  logic [VEC_W-1:0]   deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [VEC_W-1:0]   cand_w;
  logic [VEC_W-1:0]   surv_w;
  logic               m_live_w;
  logic               s_live_w;
  logic               sel_take_w;
  logic [CAUSE_W-1:0] sel_cause_w;

  irq_gate #(.VEC_W(VEC_W)) u_gate (
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .cand_o  (cand_w),
    .m_live_o(m_live_w),
    .s_live_o(s_live_w),
    .surv_o  (surv_w)
  );

  irq_lowest_pick #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_pick (
    .vec_i(surv_w),
    .any_o(sel_take_w),
    .idx_o(sel_cause_w)
  );

  irq_out_stage #(.CAUSE_W(CAUSE_W), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (sel_take_w),
    .cause_i(sel_cause_w),
    .take_o (take_o),
    .cause_o(cause_o)
  );
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
  parameter int VEC_W   = 16,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VEC_W-1:0]   deleg_i,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic [VEC_W-1:0]   cand_w,
  input logic [VEC_W-1:0]   surv_w,
  input logic               m_live_w,
  input logic               s_live_w,
  input logic               sel_take_w,
  input logic [CAUSE_W-1:0] sel_cause_w
);
  localparam logic [VEC_W-1:0] ONE = VEC_W'(1);

  AST_PICK_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_take_w |-> cand_w[sel_cause_w]); // R1
  AST_MACH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !m_gie_i) |-> !m_live_w); // R2
  AST_SUPER_CLOSED_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3) |-> !s_live_w); // R3
  AST_DELEG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_take_w && deleg_i[sel_cause_w]) |-> s_live_w); // R4
  AST_NONDELEG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_take_w && !deleg_i[sel_cause_w]) |-> m_live_w); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_take_w |-> ((surv_w & ((ONE << sel_cause_w) - ONE)) == '0)); // R5
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_take_w |-> (surv_w == '0 && sel_cause_w == '0)); // R6
endmodule

bind irq_prio_select irq_prio_select_chk #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .deleg_i    (deleg_i),
  .priv_i     (priv_i),
  .m_gie_i    (m_gie_i),
  .cand_w     (cand_w),
  .surv_w     (surv_w),
  .m_live_w   (m_live_w),
  .s_live_w   (s_live_w),
  .sel_take_w (sel_take_w),
  .sel_cause_w(sel_cause_w)
);

// File: tb/sim_irq_prio_select.sv
`timescale 1ns/1ps
module sim_irq_prio_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pend_i = '0, en_i = '0, deleg_i = '0;
  logic [1:0]  priv_i = 2'd0;
  logic        m_gie_i = 1'b0, s_gie_i = 1'b0;
  logic        take_o;
  logic [3:0]  cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_select u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
    .take_o(take_o), .cause_o(cause_o)
  );

  // reference: scan from the top down, overwriting with each bit allowed at this privilege
  function automatic logic [4:0] ref_pick(input logic [15:0] p, input logic [15:0] e,
                                          input logic [15:0] d, input logic [1:0] pr,
                                          input logic mg, input logic sg);
    logic [4:0] r;
    logic m_ok, s_ok;
    m_ok = (pr == 2'd0) || (pr == 2'd1) || (pr == 2'd3 && mg);
    s_ok = (pr == 2'd0) || (pr == 2'd1 && sg);
    r = 5'd0;
    for (int k = 15; k >= 0; k--) begin
      if (p[k] && e[k] && (d[k] ? s_ok : m_ok)) r = {1'b1, 4'(k)};
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic exp_take, input logic [3:0] exp_cause);
    checks++;
    if (take_o !== exp_take || cause_o !== exp_cause) begin
      errors++;
      $display("FAIL %s: got take=%0b cause=%0d, expected take=%0b cause=%0d",
               tag, take_o, cause_o, exp_take, exp_cause);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] p, input logic [15:0] e,
                       input logic [15:0] d, input logic [1:0] pr,
                       input logic mg, input logic sg);
    logic [4:0] x;
    @(negedge clk);
    pend_i = p; en_i = e; deleg_i = d; priv_i = pr; m_gie_i = mg; s_gie_i = sg;
    #2;
    x = ref_pick(p, e, d, pr, mg, sg);
    check(tag, x[4], x[3:0]);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] pr;
    void'($urandom(32'd1234));
    #1;
    check("R6 reset idle", 1'b0, 4'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: pending without enable, and enable without pending
    apply("R1 pend-only", 16'h00F0, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0);
    apply("R1 en-only",   16'h0000, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b1);
    apply("R1 overlap",   16'h0C00, 16'h0800, 16'h0000, 2'd3, 1'b1, 1'b0);
    // R2: machine mode, enable clear vs set; supervisor ignores m_gie
    apply("R2 M closed",  16'h0080, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1);
    apply("R2 M open",    16'h0080, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
    apply("R2 S below M", 16'h0080, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0);
    // R3: supervisor gate by privilege
    apply("R3 U open",    16'h0020, 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0);
    apply("R3 S closed",  16'h0020, 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b0);
    apply("R3 S open",    16'h0020, 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b1);
    apply("R3 M closed",  16'h0020, 16'hFFFF, 16'hFFFF, 2'd3, 1'b1, 1'b1);
    // R4/R5: low delegated bit blocked, higher machine bit wins
    apply("R4 skip deleg M", 16'h0202, 16'hFFFF, 16'h0002, 2'd3, 1'b1, 1'b1);
    apply("R4 skip deleg S", 16'h0202, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0);
    apply("R4 deleg passes", 16'h0202, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b1);
    // R5: lowest index, extremes
    apply("R5 bit0",      16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    apply("R5 bit15",     16'h8000, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    apply("R5 pair",      16'h1100, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    // R6: nothing survives
    apply("R6 none",      16'hFFFF, 16'hFFFF, 16'h00FF, 2'd3, 1'b0, 1'b1);

    // R7: combinational default: result visible before the next edge
    @(negedge clk);
    pend_i = 16'h0040; en_i = 16'hFFFF; deleg_i = '0; priv_i = 2'd0;
    #1;
    check("R7 same cycle", 1'b1, 4'd6);

    // random phase covering R1-style gating through R5, privilege never 2 (R8)
    for (int n = 0; n < 3000; n++) begin
      case ($urandom_range(0, 2))
        0: pr = 2'd0;
        1: pr = 2'd1;
        default: pr = 2'd3;
      endcase
      apply("R5 random", 16'($urandom), 16'($urandom) | 16'($urandom),
            16'($urandom), pr, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule